// File: doc/BRIEF.md
# Branch Sync Trace Message Packer

This block turns one branch event into a single trace message of variable length, ready for a serializer downstream. Each request carries a format selector, a source identifier, an instruction count, a branch history word and the full branch target address. The block puts a fixed 6-bit type code at bit 0 and the 4-bit source identifier above it. It then stacks the instruction count, the history word (history format only) and the target address, in that order, toward the MSB.

Every variable field is cut down to the span ending at its most significant set bit. A zero value still takes one bit. The finished message therefore runs from 12 to 50 bits for the two plain sync formats and from 13 to 82 bits for the history format. Along with the packed vector, the block reports the total length and a marker vector that flags the top bit of each variable field. A downstream serializer uses these to find the field boundaries.

Requests enter through a valid/ready handshake. A registered output stage holds each message until the consumer takes it.

Top module: `bsm_packer`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `msg_valid` is 0 and `req_ready` is 1.
- R2: Bits [5:0] of the message hold the type code: 6'b001011 for `req_kind` 2'd0 (direct), 6'b001100 for 2'd1 (indirect) and 6'b011101 for 2'd2 (history). `req_kind` 2'd3 is packed exactly as a direct message.
- R3: Bits [9:6] hold `req_src`.
- R4: The instruction count starts at bit 10. Its width is the index of its highest set bit plus one, and a zero count takes 1 bit.
- R5: The history field sits directly above the count, trimmed the same way, and is present only for `req_kind` 2'd2. For the other kinds, `req_hist` has no effect on any output.
- R6: The target address sits directly above the last field before it, as the full address trimmed the same way.
- R7: `msg_len` equals the total packed width: 12..50 for non-history messages and 13..82 for history messages. Every bit of `msg_bits` at or above `msg_len` is 0.
- R8: `msg_mark` has a bit set at the top bit of the count, of the history field (when present) and of the address, and no other bits set.
- R9: A request is taken at a clock edge when `req_valid` and `req_ready` are both 1, and its message is shown with `msg_valid` 1 after that edge. `req_ready` equals `!msg_valid || msg_ready`.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the message, length and marker stay unchanged and no new request is taken.
- R11: With `msg_ready` held at 1, a new request is taken on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Branch event present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_kind | input | 2 | Message format: 0 direct, 1 indirect, 2 history, 3 as direct |
| req_src | input | 4 | Source identifier |
| req_icnt | input | 8 | Instruction count since last message |
| req_hist | input | 32 | Branch history word |
| req_addr | input | 32 | Full branch target address |
| msg_valid | output | 1 | Packed message available |
| msg_ready | input | 1 | Consumer takes the message this cycle |
| msg_bits | output | 82 | Packed message, LSB-first |
| msg_mark | output | 82 | Top-bit flags of each variable field |
| msg_len | output | 7 | Number of valid message bits |

## Verification
The bench builds the block with its default widths: a 4-bit source, an 8-bit count and 32-bit history and address fields. With these widths, the 12-bit and 82-bit extremes of the length range are both reachable, using all-zero and all-ones fields. Random values are shifted right by random amounts so that every trimmed width from 1 bit to full width occurs, and a random consumer stall pattern exercises the hold and back-to-back cases.

// File: rtl/bsm_pkg.sv
// Shared types and constants for the branch sync message packer.
// Assumes the type code field is always 6 bits wide.
package bsm_pkg;

    localparam int TCODE_W = 6;

    typedef enum logic [1:0] {
        BK_DIRECT   = 2'd0,
        BK_INDIRECT = 2'd1,
        BK_HISTORY  = 2'd2,
        BK_SPARE    = 2'd3
    } br_kind_t;

    localparam logic [TCODE_W-1:0] TC_DIRECT   = 6'b001011;
    localparam logic [TCODE_W-1:0] TC_INDIRECT = 6'b001100;
    localparam logic [TCODE_W-1:0] TC_HISTORY  = 6'b011101;

    // Map a message kind to its type code; the spare kind packs as direct.
    function automatic logic [TCODE_W-1:0] tcode_of(br_kind_t kind);
        case (kind)
            BK_INDIRECT: return TC_INDIRECT;
            BK_HISTORY:  return TC_HISTORY;
            default:     return TC_DIRECT;
        endcase
    endfunction

endpackage

// File: rtl/bsm_field_trim.sv
// Finds the significant width of one variable-length field: the index of
// its highest set bit plus one, or 1 when the value is zero.
// Assumes W >= 1. Purely combinational.
module bsm_field_trim #(
    parameter int W = 32,
    localparam int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [LW-1:0] used_len
);

    // Scan upward; the last set bit seen sets the width.
    always_comb begin
        used_len = LW'(1);
        for (int i = 0; i < W; i++) begin
            if (value[i]) used_len = LW'(i + 1);
        end
    end

    // Check the width against the value once inputs are known.
    always_comb begin
        if (!$isunknown(value)) begin
            AST_TRIM_TOP_SET: assert (value == '0 || value[used_len - LW'(1)]); // R4
            AST_TRIM_NO_SPILL: assert ((value >> used_len) == '0); // R4
        end
    end

endmodule

// File: rtl/bsm_assemble.sv
// Packs the type code, source id and trimmed variable fields LSB-first,
// and computes the total length and per-field top-bit markers.
// Assumes each field value is zero above its reported width.
module bsm_assemble
    import bsm_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int ICNT_W = 8,
    parameter int HIST_W = 32,
    parameter int ADDR_W = 32,
    localparam int HDR_W = TCODE_W + SRC_W,
    localparam int MSG_W = HDR_W + ICNT_W + HIST_W + ADDR_W,
    localparam int LEN_W = $clog2(MSG_W + 1),
    localparam int IL_W  = $clog2(ICNT_W + 1),
    localparam int HL_W  = $clog2(HIST_W + 1),
    localparam int AL_W  = $clog2(ADDR_W + 1)
) (
    input  br_kind_t          kind,
    input  logic [SRC_W-1:0]  src,
    input  logic [ICNT_W-1:0] icnt,
    input  logic [HIST_W-1:0] hist,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IL_W-1:0]   icnt_len,
    input  logic [HL_W-1:0]   hist_len,
    input  logic [AL_W-1:0]   addr_len,
    output logic [MSG_W-1:0]  bits,
    output logic [MSG_W-1:0]  mark,
    output logic [LEN_W-1:0]  len
);

    logic             has_hist;
    logic [LEN_W-1:0] off_hist;
    logic [LEN_W-1:0] off_addr;
    logic [LEN_W-1:0] end_icnt;
    logic [LEN_W-1:0] end_hist;
    logic [LEN_W-1:0] end_addr;

    // Work out where each field starts and ends.
    always_comb begin
        has_hist = (kind == BK_HISTORY);
        off_hist = LEN_W'(HDR_W) + LEN_W'(icnt_len);
        off_addr = off_hist + (has_hist ? LEN_W'(hist_len) : '0);
        len      = off_addr + LEN_W'(addr_len);
        end_icnt = off_hist - LEN_W'(1);
        end_hist = off_addr - LEN_W'(1);
        end_addr = len - LEN_W'(1);
    end

    // Place every field at its offset in the message vector.
    always_comb begin
        bits = MSG_W'(tcode_of(kind))
             | (MSG_W'(src)  << TCODE_W)
             | (MSG_W'(icnt) << HDR_W)
             | (has_hist ? (MSG_W'(hist) << off_hist) : '0)
             | (MSG_W'(addr) << off_addr);
    end

    // Flag the top bit of each variable field.
    always_comb begin
        for (int i = 0; i < MSG_W; i++) begin
            mark[i] = (LEN_W'(i) == end_icnt)
                   || (has_hist && LEN_W'(i) == end_hist)
                   || (LEN_W'(i) == end_addr);
        end
    end

endmodule

// File: rtl/bsm_out_reg.sv
// Output holding stage: captures one packed message when the request side
// hands one over and keeps it steady until the consumer takes it.
// Assumes a synchronous active-low reset.
module bsm_out_reg
    import bsm_pkg::*;
#(
    parameter int MSG_W       = 82,
    parameter int LEN_W       = 7,
    parameter int MIN_LEN     = 12,
    parameter int NONHIST_MAX = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MSG_W-1:0] in_bits,
    input  logic [MSG_W-1:0] in_mark,
    input  logic [LEN_W-1:0] in_len,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [MSG_W-1:0] msg_bits,
    output logic [MSG_W-1:0] msg_mark,
    output logic [LEN_W-1:0] msg_len
);

    // The stage frees up when it is empty or being drained this cycle.
    always_comb in_ready = !msg_valid || msg_ready;

    // Load a new message on acceptance; drop valid when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_bits  <= '0;
            msg_mark  <= '0;
            msg_len   <= '0;
        end else if (in_valid && in_ready) begin
            msg_valid <= 1'b1;
            msg_bits  <= in_bits;
            msg_mark  <= in_mark;
            msg_len   <= in_len;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> msg_valid); // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_bits)
                                   && $stable(msg_len) && $stable(msg_mark)); // R10
    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_len >= LEN_W'(MIN_LEN)); // R7
    AST_NONHIST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_bits[TCODE_W-1:0] != TC_HISTORY
        |-> msg_len <= LEN_W'(NONHIST_MAX)); // R7
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_bits >> msg_len) == '0); // R7
    AST_MARK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_mark[msg_len - LEN_W'(1)] && (msg_mark >> msg_len) == '0); // R8

endmodule

// File: rtl/bsm_packer.sv
// Branch sync trace message packer top: trims the count, history and
// address fields, assembles the variable-length message and holds it in
// a handshake output stage. Assumes all field widths are at least 1.
module bsm_packer
    import bsm_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int ICNT_W = 8,
    parameter int HIST_W = 32,
    parameter int ADDR_W = 32,
    localparam int HDR_W = TCODE_W + SRC_W,
    localparam int MSG_W = HDR_W + ICNT_W + HIST_W + ADDR_W,
    localparam int LEN_W = $clog2(MSG_W + 1),
    localparam int IL_W  = $clog2(ICNT_W + 1),
    localparam int HL_W  = $clog2(HIST_W + 1),
    localparam int AL_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ICNT_W-1:0] req_icnt,
    input  logic [HIST_W-1:0] req_hist,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [MSG_W-1:0]  msg_bits,
    output logic [MSG_W-1:0]  msg_mark,
    output logic [LEN_W-1:0]  msg_len
);

    logic [IL_W-1:0]  icnt_len;
    logic [HL_W-1:0]  hist_len;
    logic [AL_W-1:0]  addr_len;
    logic [MSG_W-1:0] pk_bits;
    logic [MSG_W-1:0] pk_mark;
    logic [LEN_W-1:0] pk_len;

    bsm_field_trim #(.W(ICNT_W)) u_trim_icnt (.value(req_icnt), .used_len(icnt_len));
    bsm_field_trim #(.W(HIST_W)) u_trim_hist (.value(req_hist), .used_len(hist_len));
    bsm_field_trim #(.W(ADDR_W)) u_trim_addr (.value(req_addr), .used_len(addr_len));

    bsm_assemble #(
        .SRC_W (SRC_W),
        .ICNT_W(ICNT_W),
        .HIST_W(HIST_W),
        .ADDR_W(ADDR_W)
    ) u_asm (
        .kind    (br_kind_t'(req_kind)),
        .src     (req_src),
        .icnt    (req_icnt),
        .hist    (req_hist),
        .addr    (req_addr),
        .icnt_len(icnt_len),
        .hist_len(hist_len),
        .addr_len(addr_len),
        .bits    (pk_bits),
        .mark    (pk_mark),
        .len     (pk_len)
    );

    bsm_out_reg #(
        .MSG_W      (MSG_W),
        .LEN_W      (LEN_W),
        .MIN_LEN    (HDR_W + 2),
        .NONHIST_MAX(HDR_W + ICNT_W + ADDR_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_bits  (pk_bits),
        .in_mark  (pk_mark),
        .in_len   (pk_len),
        .msg_valid(msg_valid),
        .msg_ready(msg_ready),
        .msg_bits (msg_bits),
        .msg_mark (msg_mark),
        .msg_len  (msg_len)
    );

endmodule

// File: tb/bsm_packer_tb_top.sv
`timescale 1ns/1ps
// Bench for the branch sync message packer: a behavioural reference model
// updated every clock and compared at each falling edge, plus directed cases.
module bsm_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [3:0]  req_src = '0;
    logic [7:0]  req_icnt = '0;
    logic [31:0] req_hist = '0;
    logic [31:0] req_addr = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [81:0] msg_bits;
    logic [81:0] msg_mark;
    logic [6:0]  msg_len;

    int total = 0;
    int bad = 0;

    bit          exp_v = 1'b0;
    logic [81:0] exp_b = '0;
    logic [81:0] exp_m = '0;
    int          exp_l = 0;

    always #10 clk = ~clk;

    bsm_packer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_icnt(req_icnt),
        .req_hist(req_hist), .req_addr(req_addr), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_bits(msg_bits), .msg_mark(msg_mark),
        .msg_len(msg_len)
    );

    task automatic chk(input bit ok, input string tag, input logic [81:0] act, input logic [81:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Significant width: strip zeros from the top, keep at least one bit.
    function automatic int sig_w(input logic [31:0] v, input int w);
        int n = w;
        while (n > 1 && !v[n-1]) n--;
        return n;
    endfunction

    // Reference packing, appended bit by bit from the LSB.
    task automatic ref_pack();
        logic [81:0] b = '0;
        logic [81:0] m = '0;
        int p = 0;
        int n;
        logic [5:0] tc;
        tc = (req_kind == 2'd1) ? 6'b001100 : (req_kind == 2'd2) ? 6'b011101 : 6'b001011;
        for (int k = 0; k < 6; k++) begin b[p] = tc[k]; p++; end
        for (int k = 0; k < 4; k++) begin b[p] = req_src[k]; p++; end
        n = sig_w({24'd0, req_icnt}, 8);
        for (int k = 0; k < n; k++) begin b[p] = req_icnt[k]; p++; end
        m[p-1] = 1'b1;
        if (req_kind == 2'd2) begin
            n = sig_w(req_hist, 32);
            for (int k = 0; k < n; k++) begin b[p] = req_hist[k]; p++; end
            m[p-1] = 1'b1;
        end
        n = sig_w(req_addr, 32);
        for (int k = 0; k < n; k++) begin b[p] = req_addr[k]; p++; end
        m[p-1] = 1'b1;
        exp_b = b;
        exp_m = m;
        exp_l = p;
    endtask

    task automatic compare();
        if (!rst_n) return;
        chk(msg_valid == exp_v, "R9 msg_valid", 82'(msg_valid), 82'(exp_v));
        chk(req_ready == (!exp_v || msg_ready), "R9 req_ready", 82'(req_ready), 82'(!exp_v || msg_ready));
        if (exp_v) begin
            chk(msg_bits == exp_b, "R2/R3/R4/R5/R6 msg_bits", msg_bits, exp_b);
            chk(int'(msg_len) == exp_l, "R7 msg_len", 82'(msg_len), 82'(exp_l));
            chk(msg_mark == exp_m, "R8 msg_mark", msg_mark, exp_m);
        end
    endtask

    // Advance one clock: update the model with the inputs the edge samples.
    task automatic tick();
        if (!rst_n) exp_v = 1'b0;
        else if (req_valid && (!exp_v || msg_ready)) begin ref_pack(); exp_v = 1'b1; end
        else if (msg_ready) exp_v = 1'b0;
        @(negedge clk);
        compare();
    endtask

    task automatic put(input logic [1:0] k, input logic [3:0] s, input logic [7:0] c,
                       input logic [31:0] h, input logic [31:0] a);
        req_valid = 1'b1; req_kind = k; req_src = s; req_icnt = c; req_hist = h; req_addr = a;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin : stim
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        chk(msg_valid == 1'b0, "R1 msg_valid after reset", 82'(msg_valid), 82'(0));
        chk(req_ready == 1'b1, "R1 req_ready after reset", 82'(req_ready), 82'(1));

        // Shortest direct message: all variable fields zero.
        put(2'd0, 4'hA, 8'd0, 32'd0, 32'd0);
        chk(msg_len == 7'd12, "R4 R7 minimum direct length", 82'(msg_len), 82'(12));
        chk(msg_bits == 82'd651, "R2 R3 direct code and source", msg_bits, 82'd651);
        chk(msg_mark == 82'hC00, "R8 marks at bits 10 and 11", msg_mark, 82'hC00);
        tick();

        // Longest indirect message.
        put(2'd1, 4'hF, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk(msg_len == 7'd50, "R7 maximum non-history length", 82'(msg_len), 82'(50));
        chk(msg_bits[5:0] == 6'b001100, "R2 indirect code", 82'(msg_bits[5:0]), 82'(6'b001100));
        tick();

        // Longest history message.
        put(2'd2, 4'h3, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk(msg_len == 7'd82, "R5 R7 maximum history length", 82'(msg_len), 82'(82));
        chk(msg_bits[5:0] == 6'b011101, "R2 history code", 82'(msg_bits[5:0]), 82'(6'b011101));
        tick();

        // Shortest history message.
        put(2'd2, 4'h0, 8'd0, 32'd0, 32'd0);
        chk(msg_len == 7'd13, "R7 minimum history length", 82'(msg_len), 82'(13));
        chk(msg_mark == 82'h1C00, "R8 marks at bits 10, 11, 12", msg_mark, 82'h1C00);
        tick();

        // Spare kind packs as direct; address placement.
        put(2'd3, 4'h5, 8'd3, 32'd0, 32'd5);
        chk(msg_bits[5:0] == 6'b001011, "R2 spare kind as direct", 82'(msg_bits[5:0]), 82'(6'b001011));
        chk(msg_len == 7'd15, "R4 R6 trimmed length", 82'(msg_len), 82'(15));
        chk(msg_bits[14:12] == 3'b101, "R6 address above count", 82'(msg_bits[14:12]), 82'(5));
        tick();

        // History word must not matter for a non-history kind.
        put(2'd1, 4'h1, 8'd1, 32'h0000_FFFF, 32'd1);
        chk(msg_len == 7'd12, "R5 history ignored length", 82'(msg_len), 82'(12));
        chk((msg_bits >> 12) == '0, "R5 history ignored bits", msg_bits >> 12, 82'd0);
        tick();

        // R10: stall the consumer while new requests wait.
        put(2'd2, 4'h7, 8'h12, 32'h0000_00F0, 32'h8000_0001);
        msg_ready = 1'b0;
        req_valid = 1'b1; req_icnt = 8'h01; req_addr = 32'h2;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(req_ready == 1'b0, "R10 no accept while stalled", 82'(req_ready), 82'(0));
            chk(msg_bits[17:10] == 8'h12 && msg_valid, "R10 message held", 82'(msg_bits[17:10]), 82'(8'h12));
        end
        msg_ready = 1'b1;
        tick();
        req_valid = 1'b0;
        tick();

        // R11: back-to-back acceptance.
        msg_ready = 1'b1;
        req_valid = 1'b1; req_kind = 2'd0;
        for (int i = 0; i < 5; i++) begin
            req_icnt = 8'(i + 1); req_addr = 32'(i * 37);
            tick();
            chk(req_ready && msg_valid, "R11 accept every cycle", 82'({req_ready, msg_valid}), 82'(3));
            chk(msg_bits[10 + (i + 1 > 1 ? $clog2(i + 2) : 1) - 1] == 1'b1, "R11 newest count shown",
                82'(msg_bits[15:10]), 82'(i + 1));
        end
        req_valid = 1'b0;
        tick();

        // Random traffic with consumer stalls.
        for (int i = 0; i < 3000; i++) begin
            req_valid = ($urandom % 4) != 0;
            msg_ready = ($urandom % 4) != 0;
            req_kind  = 2'($urandom);
            req_src   = 4'($urandom);
            req_icnt  = 8'($urandom) >> ($urandom % 9);
            req_hist  = ($urandom % 8 == 0) ? 32'd0 : ($urandom >> ($urandom % 32));
            req_addr  = ($urandom % 8 == 0) ? 32'd0 : ($urandom >> ($urandom % 32));
            tick();
        end
        req_valid = 1'b0;
        msg_ready = 1'b1;
        repeat (2) tick();
        summary();
    end

endmodule